// File: doc/BRIEF.md
# ECC Syndrome Corrector

This block takes two error-check words for a 256-byte data chunk: the word read back from storage and the word freshly computed from the data as it arrived. It decides whether the chunk is clean, whether only the stored check word was damaged, whether exactly one data bit flipped (and where), or whether the damage cannot be repaired. The check code pairs eleven even-parity bits with their eleven complementary parity bits, so a single flipped data bit shows up as eleven syndrome ones whose two 11-bit halves are exact complements. The lower half then gives the position of the flipped bit.

The caller pulses `start` with both words on the inputs and receives one registered result per chunk, marked by `done`. In wide mode the caller supplies two pairs of words covering a 512-byte block. The block checks the lower 256 bytes and then the upper 256 bytes on consecutive cycles and reports a combined uncorrectable flag with the second result. The block does not modify the data buffer and does not generate check words.

Top module: `ecc_syndrome_corrector`

## Requirements
- R1: While reset is asserted and after its release, `done`, `last` and `uncorr_any` are 0, `status` is 0, and both indices are 0.
- R2: The syndrome is the XOR of the low 22 bits of the two words. If the syndrome is zero, or if either word's low 22 bits are all zero, the status is CLEAN (code 0).
- R3: Otherwise, if the syndrome has exactly one bit set, the status is CHECKWORD (code 1) and both indices are 0.
- R4: Otherwise, if the syndrome has exactly eleven ones and syndrome[10:0] XOR syndrome[21:11] is all ones (0x7FF), the status is FIXABLE (code 2). In that case `bit_idx` = syndrome[2:0] and `byte_idx` = syndrome[10:3], plus 256 for the upper half of a wide request.
- R5: Every other syndrome gives status BROKEN (code 3). For any status other than FIXABLE, `byte_idx` and `bit_idx` are 0.
- R6: A narrow request (`wide` = 0) gives exactly one `done` pulse, with `last` = 1, in the cycle after the cycle in which `start` is sampled.
- R7: A wide request checks bits [23:0] of both inputs first. That result comes one cycle after `start` with `last` = 0. The block then checks bits [47:24], which were captured at `start`. That result comes on the next cycle with `last` = 1.
- R8: When `last` = 1, `uncorr_any` is 1 exactly when any half of the request was BROKEN.
- R9: A `start` that arrives while the upper half of a wide request is still pending is ignored. It produces no extra result and does not change the captured upper words.
- R10: Bits [23:22] of each 24-bit word have no effect on any result.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a check using the current inputs |
| wide | input | 1 | 1 = two 256-byte halves (512-byte block), 0 = single chunk |
| calc_code | input | 48 | Computed words; [23:0] lower chunk, [47:24] upper chunk |
| stored_code | input | 48 | Stored words; same layout as calc_code |
| done | output | 1 | Result valid this cycle |
| last | output | 1 | Final result of the current request |
| status | output | 2 | 0 CLEAN, 1 CHECKWORD, 2 FIXABLE, 3 BROKEN |
| byte_idx | output | 9 | Failing byte index when FIXABLE, otherwise 0 |
| bit_idx | output | 3 | Failing bit index when FIXABLE, otherwise 0 |
| uncorr_any | output | 1 | Any half BROKEN; meaningful when last = 1 |

## Verification
The bench uses the default parameters: eleven parity pairs in 24-bit words. With these values the full byte range 0 to 255 is reachable, including the extreme positions 0 and 2047. The two unused pad bits of each word can be toggled, and the 256 offset of the upper half is visible on the ninth index bit. Correctable patterns are built as a stored word XOR a complementary pair {~k, k}. The bench also covers an eleven-ones syndrome whose halves are not complements, a start that arrives while a wide request is pending, and wide requests whose combined flag must depend on the lower half only.

// File: rtl/ecc_syn_pkg.sv
package ecc_syn_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN  = 2'd0,
    ST_CHECK  = 2'd1,
    ST_FIX    = 2'd2,
    ST_BROKEN = 2'd3
  } ecc_status_e;
endpackage

// File: rtl/ecc_popcnt.sv
module ecc_popcnt #(
  parameter int W = 22,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import ecc_syn_pkg::*;
#(
  parameter int PAR_W = 11,
  localparam int SYN_W = 2 * PAR_W,
  localparam int POP_W = $clog2(SYN_W + 1)
) (
  input  logic [SYN_W-1:0] calc,
  input  logic [SYN_W-1:0] stor,
  output ecc_status_e      status,
  output logic [PAR_W-1:0] fix_idx
);
  logic [SYN_W-1:0] syn;
  logic [PAR_W-1:0] syn_lo, syn_hi;
  logic [POP_W-1:0] ones;

  assign syn    = calc ^ stor;
  assign syn_lo = syn[PAR_W-1:0];
  assign syn_hi = syn[SYN_W-1:PAR_W];

  ecc_popcnt #(.W(SYN_W)) u_pop (.vec(syn), .cnt(ones));

  always_comb begin
    status  = ST_BROKEN;
    fix_idx = '0;
    if (syn == '0 || calc == '0 || stor == '0) begin
      status = ST_CLEAN;
    end else if (ones == POP_W'(1)) begin
      status = ST_CHECK;
    end else if (ones == POP_W'(PAR_W) && (syn_lo ^ syn_hi) == '1) begin
      status  = ST_FIX;
      fix_idx = syn_lo;
    end
  end
endmodule

// File: rtl/ecc_syndrome_corrector.sv
module ecc_syndrome_corrector
  import ecc_syn_pkg::*;
#(
  parameter int PAR_W  = 11,
  parameter int CODE_W = 24,
  localparam int SYN_W = 2 * PAR_W,
  localparam int BIT_W = 3,
  localparam int IDX_W = PAR_W - BIT_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                wide,
  input  logic [2*CODE_W-1:0] calc_code,
  input  logic [2*CODE_W-1:0] stored_code,
  output logic                done,
  output logic                last,
  output logic [1:0]          status,
  output logic [IDX_W-1:0]    byte_idx,
  output logic [BIT_W-1:0]    bit_idx,
  output logic                uncorr_any
);
  // pad bits above the meaningful syndrome width never reach the logic
  logic unused_pad;
  assign unused_pad = ^{calc_code[2*CODE_W-1:CODE_W+SYN_W], calc_code[CODE_W-1:SYN_W],
                        stored_code[2*CODE_W-1:CODE_W+SYN_W], stored_code[CODE_W-1:SYN_W]};

  // sequencer state
  logic             pend_q, pend_d;
  logic [SYN_W-1:0] hi_calc_q, hi_stor_q;
  logic             lo_bad_q, lo_bad_d;
  logic             fire, cap_en, out_en;

  // output registers
  logic              done_q, done_d, last_q, last_d, any_q, any_d;
  ecc_status_e       st_q, st_d;
  logic [IDX_W-1:0]  byte_q, byte_d;
  logic [BIT_W-1:0]  bit_q, bit_d;

  // classifier interface
  logic [SYN_W-1:0] cls_calc, cls_stor;
  ecc_status_e      cls_st;
  logic [PAR_W-1:0] cls_idx;
  logic             cls_bad;

  assign fire   = start & ~pend_q;
  assign cap_en = fire & wide;
  assign out_en = fire | pend_q;

  assign cls_calc = pend_q ? hi_calc_q : calc_code[SYN_W-1:0];
  assign cls_stor = pend_q ? hi_stor_q : stored_code[SYN_W-1:0];

  ecc_classify #(.PAR_W(PAR_W)) u_cls (
    .calc   (cls_calc),
    .stor   (cls_stor),
    .status (cls_st),
    .fix_idx(cls_idx)
  );

  assign cls_bad = (cls_st == ST_BROKEN);

  always_comb begin
    pend_d   = cap_en;
    lo_bad_d = lo_bad_q;
    if (fire) lo_bad_d = cls_bad;
    done_d = out_en;
    last_d = (fire & ~wide) | pend_q;
    st_d   = cls_st;
    any_d  = pend_q ? (lo_bad_q | cls_bad) : cls_bad;
    if (cls_st == ST_FIX) begin
      byte_d = {pend_q, cls_idx[PAR_W-1:BIT_W]};
      bit_d  = cls_idx[BIT_W-1:0];
    end else begin
      byte_d = '0;
      bit_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      lo_bad_q  <= 1'b0;
      hi_calc_q <= '0;
      hi_stor_q <= '0;
      done_q    <= 1'b0;
      last_q    <= 1'b0;
      any_q     <= 1'b0;
      st_q      <= ST_CLEAN;
      byte_q    <= '0;
      bit_q     <= '0;
    end else begin
      pend_q   <= pend_d;
      lo_bad_q <= lo_bad_d;
      done_q   <= done_d;
      last_q   <= last_d;
      if (cap_en) begin
        hi_calc_q <= calc_code[CODE_W+SYN_W-1:CODE_W];
        hi_stor_q <= stored_code[CODE_W+SYN_W-1:CODE_W];
      end
      if (out_en) begin
        st_q   <= st_d;
        byte_q <= byte_d;
        bit_q  <= bit_d;
        any_q  <= any_d;
      end
    end
  end

  assign done       = done_q;
  assign last       = last_q;
  assign status     = st_q;
  assign byte_idx   = byte_q;
  assign bit_idx    = bit_q;
  assign uncorr_any = any_q;

  // R6: narrow request answers on the next cycle as a final result
  a_r6_narrow_next: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pend_q && !wide) |=> (done && last));

  // R7: wide request answers on two consecutive cycles, final one last
  a_r7_wide_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pend_q && wide) |=> (done && !last) ##1 (done && last));

  // R9: a pending upper half never re-arms itself
  a_r9_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !pend_q);

  // R5: indices cleared unless the result is fixable
  a_r5_idx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != ST_FIX) |-> (byte_idx == '0 && bit_idx == '0));

  // R8: a broken final half is always reflected in the combined flag
  a_r8_any_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (done && last && status == ST_BROKEN) |-> uncorr_any);
endmodule

// File: tb/ecc_syndrome_corrector_test.sv
`timescale 1ns/1ps
module ecc_syndrome_corrector_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, wide;
  logic [47:0] calc_code, stored_code;
  logic        done, last, uncorr_any;
  logic [1:0]  status;
  logic [8:0]  byte_idx;
  logic [2:0]  bit_idx;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [1:0] st;
    logic [8:0] byt;
    logic [2:0] bt;
    logic       lst;
    logic       any;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  ecc_syndrome_corrector uut (
    .clk(clk), .rst_n(rst_n), .start(start), .wide(wide),
    .calc_code(calc_code), .stored_code(stored_code),
    .done(done), .last(last), .status(status),
    .byte_idx(byte_idx), .bit_idx(bit_idx), .uncorr_any(uncorr_any)
  );

  // reference classification taken from R2..R5 and R10
  function automatic void model(input logic [23:0] c, input logic [23:0] s,
                                output logic [1:0] st, output logic [10:0] k);
    logic [21:0] y;
    y = c[21:0] ^ s[21:0];
    k = '0;
    if (y == 0 || c[21:0] == 0 || s[21:0] == 0) st = 2'd0;
    else if ($countones(y) == 1) st = 2'd1;
    else if ($countones(y) == 11 && (y[10:0] ^ y[21:11]) == 11'h7FF) begin
      st = 2'd2;
      k  = y[10:0];
    end else st = 2'd3;
  endfunction

  function automatic logic [23:0] mk_fix(input logic [23:0] s, input logic [10:0] k);
    return s ^ {2'b00, ~k, k};
  endfunction

  task automatic send(input bit w, input logic [47:0] c, input logic [47:0] s,
                      input bit poke, input string tag);
    logic [1:0]  st0, st1;
    logic [10:0] k0, k1;
    exp_t e;
    model(c[23:0], s[23:0], st0, k0);
    if (!w) begin
      e = '{st0, {1'b0, k0[10:3]}, k0[2:0], 1'b1, st0 == 2'd3};
      exp_q.push_back(e); tag_q.push_back(tag);
    end else begin
      model(c[47:24], s[47:24], st1, k1);
      e = '{st0, {1'b0, k0[10:3]}, k0[2:0], 1'b0, 1'b0};
      exp_q.push_back(e); tag_q.push_back({tag, " R7 lower"});
      e = '{st1, (st1 == 2'd2) ? {1'b1, k1[10:3]} : 9'd0, k1[2:0], 1'b1,
            (st0 == 2'd3) || (st1 == 2'd3)};
      exp_q.push_back(e); tag_q.push_back({tag, " R7 upper R8"});
    end
    @(negedge clk);
    wide = w; calc_code = c; stored_code = s; start = 1'b1;
    @(negedge clk);
    if (poke) begin
      // R9: new start while the upper half is pending
      wide = 1'b0; calc_code = {24'h0F0F0F, 24'h000003};
      stored_code = {24'h3AAAAA, 24'h000000};
    end else start = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done && !finished) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R9: unexpected result st=%0d byte=%0d, expected none", status, byte_idx);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        total++;
        if (status !== e.st || byte_idx !== e.byt || bit_idx !== e.bt || last !== e.lst ||
            (e.lst && uncorr_any !== e.any)) begin
          bad++;
          $display("FAIL %s: got st=%0d byte=%0d bit=%0d last=%0b any=%0b expected st=%0d byte=%0d bit=%0d last=%0b any=%0b",
                   t, status, byte_idx, bit_idx, last, uncorr_any, e.st, e.byt, e.bt, e.lst, e.any);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] s;
    rst_n = 1'b0; start = 1'b0; wide = 1'b0; calc_code = '0; stored_code = '0;
    repeat (3) @(negedge clk);
    total++;
    if (done !== 1'b0 || last !== 1'b0 || uncorr_any !== 1'b0 || status !== 2'd0 ||
        byte_idx !== 9'd0 || bit_idx !== 3'd0) begin
      bad++;
      $display("FAIL R1: got done=%0b last=%0b st=%0d any=%0b, expected all 0", done, last, status, uncorr_any);
    end
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (done !== 1'b0 || status !== 2'd0) begin
      bad++;
      $display("FAIL R1: after release got done=%0b st=%0d, expected 0 0", done, status);
    end

    s = 24'h0ABCDE;
    send(1'b0, {24'h0, 24'h123456}, {24'h0, 24'h123456}, 1'b0, "R2 equal");
    send(1'b0, {24'h0, 24'h000000}, {24'h0, 24'h2A5A5A}, 1'b0, "R2 zero calc");
    send(1'b0, {24'h0, 24'h155455}, {24'h0, 24'h155555}, 1'b0, "R3 single");
    send(1'b0, {24'h0, mk_fix(s, 11'h4D3)}, {24'h0, s}, 1'b0, "R4 mid");
    send(1'b0, {24'h0, mk_fix(s, 11'h000)}, {24'h0, s}, 1'b0, "R4 k0");
    send(1'b0, {24'h0, mk_fix(s, 11'h7FF)}, {24'h0, s}, 1'b0, "R4 kmax");
    send(1'b0, {24'h0, 24'h000F0F ^ {2'b00, 11'h001, 11'h3FF}}, {24'h0, 24'h000F0F}, 1'b0, "R5 eleven noncomp");
    send(1'b0, {24'h0, 24'h000F0C}, {24'h0, 24'h000F0F}, 1'b0, "R5 two bits");
    send(1'b0, {24'h0, 24'h123456 ^ 24'hC00000}, {24'h0, 24'h123456}, 1'b0, "R10 pad diff");
    send(1'b0, {24'h0, 24'h400000}, {24'h0, 24'h000111}, 1'b0, "R10 pad only");
    send(1'b1, {24'h000F0C, mk_fix(s, 11'h123)}, {24'h000F0F, s}, 1'b0, "R7 fix+broken");
    send(1'b1, {24'h13579B, 24'h000F0C}, {24'h13579B, 24'h000F0F}, 1'b0, "R8 broken+clean");
    send(1'b1, {mk_fix(s, 11'h005), mk_fix(s, 11'h7FF)}, {s, s}, 1'b0, "R4 R7 fix+fix");
    send(1'b1, {mk_fix(s, 11'h2A1), 24'h155455}, {s, 24'h155555}, 1'b1, "R9 poke");
    send(1'b0, {24'h0, 24'h000F0C}, {24'h0, 24'h000F0F}, 1'b0, "R6 R8 narrow broken");

    repeat (4) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R6: got %0d results missing, expected 0", exp_q.size());
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule